// File: doc/BRIEF.md
# Dual-Drive PIO Strobe Timing Generator

This block drives the read and write strobes of a parallel-ATA channel in PIO mode when two drives share the channel. A host programs a small indexed register file. Each access request carries a drive number and a direction. For each accepted request the block runs three timed phases: address setup, active strobe and recovery. The length of each phase is a clock count taken from biased fields in the registers.

There are two timing sets, A and B. Each set holds one byte for reads and one byte for writes, and each byte gives the active length and the recovery length. The address setup length is a single shared field, so the host must program it for the slower of the two drives. A control byte decides whether drive 1 uses set B or shares set A. The timing values in force are captured when a request is accepted, so the host may reprogram the registers while a cycle is running.

Top module: `pio_cyc_gen`

## Requirements
- R1: Register index 0 holds read timing and index 1 holds write timing. A write to either index goes to set A when bit 0 of the miscellaneous register is 0 and to set B when it is 1. A read of index 0 or 1 returns the byte of the set that bit selects. Indices 2, 4 and 7 read as zero.
- R2: In a timing byte, bits 7:4 hold the active length minus 1 (1 to 16 clocks) and bits 3:0 hold the recovery length minus 2 (2 to 17 clocks).
- R3: The miscellaneous register sits at index 6 and is read back whole. Bits 5:4 hold the address setup length minus 1 (1 to 4 clocks), and this length applies to both drives. Bits 2:1 hold the ready timing minus 2. Bit 0 is the set select.
- R4: The control register sits at index 3. While it holds 0x85, drive 0 uses set A and drive 1 uses set B. While it holds any other value, both drives use set A.
- R5: Index 5 is a read-only strap register. Bit 0 reads the STRAP_SLOW parameter (1 means a 25 MHz bus, 0 means 33 MHz), and writes to index 5 have no effect.
- R6: An accepted request runs setup, then active, then recovery, with each phase lasting exactly its decoded number of clocks.
- R7: The read strobe is asserted when the request direction is 0 and the write strobe when it is 1. The strobe is high only during the active phase, and the two strobes are never high together.
- R8: A request is accepted only while busy_o is low. busy_o goes high in the clock after acceptance. A request raised while busy is dropped.
- R9: done_o pulses for one clock on the last recovery clock, and busy_o is low in the following clock.
- R10: A register write made while a cycle is running changes only cycles accepted later.
- R11: After reset, all timing bytes, the control register and the miscellaneous register are zero, and busy_o, both strobes and done_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write enable |
| reg_idx_i | input | 3 | Register index for writes and reads |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data for reg_idx_i (combinational) |
| req_i | input | 1 | Access request |
| req_drive_i | input | 1 | Drive number of the request |
| req_write_i | input | 1 | Direction: 1 write, 0 read |
| busy_o | output | 1 | A cycle is running |
| rd_strobe_o | output | 1 | Read strobe |
| wr_strobe_o | output | 1 | Write strobe |
| done_o | output | 1 | Last recovery clock |

## Verification
The bench drives the extreme encodings: an active length of 16 with the minimum recovery, and an active length of 1 with the maximum recovery of 17. A decoder that drops the bias or swaps the two nibbles therefore produces wrong phase counts. It runs drive 1 both with and without the split control value, so a design that ignores the control register, or that routes drive 1 to the wrong set, times drive 1 with set A's values or B's. It rewrites set A in the middle of a running cycle and pokes a request while busy. A design that reads live registers alters the cycle in flight, and one that does not gate acceptance starts a cycle the bench does not expect. Finally, it writes to the strap index and reads back the selected set, which catches an unmasked write or a wrong read mux.

// File: rtl/pio_cyc_pkg.sv
package pio_cyc_pkg;
  localparam int IDX_W  = 3;
  localparam int DATA_W = 8;
  localparam int ACT_W  = 4;
  localparam int REC_W  = 4;
  localparam int SET_W  = 2;
  localparam int NUM_SETS = 2;
  localparam int CNT_W  = REC_W + 1;

  localparam logic [IDX_W-1:0] IDX_RD_TIM = 3'd0;
  localparam logic [IDX_W-1:0] IDX_WR_TIM = 3'd1;
  localparam logic [IDX_W-1:0] IDX_CTRL   = 3'd3;
  localparam logic [IDX_W-1:0] IDX_STRAP  = 3'd5;
  localparam logic [IDX_W-1:0] IDX_MISC   = 3'd6;
  localparam logic [DATA_W-1:0] CTRL_SPLIT = 8'h85;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_ACTIVE, PH_RECOV} phase_e;

  typedef struct packed {
    logic [SET_W-1:0] setup_m1;
    logic [ACT_W-1:0] act_m1;
    logic [REC_W-1:0] rec_m2;
  } timing_t;
endpackage

// File: rtl/pio_cyc_regs.sv
module pio_cyc_regs
  import pio_cyc_pkg::*;
#(
  parameter bit STRAP_SLOW = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              drive_i,
  input  logic              write_i,
  output timing_t           tim_o
);
  logic [DATA_W-1:0] ctrl_q, misc_q;
  logic [NUM_SETS-1:0][DATA_W-1:0] rd_all, wr_all;
  logic sel;
  logic use_set;
  logic [DATA_W-1:0] tim_byte;

  assign sel = misc_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      misc_q <= '0;
    end else if (we_i) begin
      if (idx_i == IDX_CTRL) ctrl_q <= wdata_i;
      if (idx_i == IDX_MISC) misc_q <= wdata_i;
    end
  end

  for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
    logic [DATA_W-1:0] rd_q, wr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rd_q <= '0;
        wr_q <= '0;
      end else if (we_i && (32'(sel) == g)) begin
        if (idx_i == IDX_RD_TIM) rd_q <= wdata_i;
        if (idx_i == IDX_WR_TIM) wr_q <= wdata_i;
      end
    end
    assign rd_all[g] = rd_q;
    assign wr_all[g] = wr_q;
  end

  always_comb begin
    unique case (idx_i)
      IDX_RD_TIM: rdata_o = rd_all[sel];
      IDX_WR_TIM: rdata_o = wr_all[sel];
      IDX_CTRL:   rdata_o = ctrl_q;
      IDX_STRAP:  rdata_o = {{(DATA_W-1){1'b0}}, STRAP_SLOW};
      IDX_MISC:   rdata_o = misc_q;
      default:    rdata_o = '0;
    endcase
  end

  // per-drive split only with the exact control value
  assign use_set  = (ctrl_q == CTRL_SPLIT) ? drive_i : 1'b0;
  assign tim_byte = write_i ? wr_all[use_set] : rd_all[use_set];
  assign tim_o.setup_m1 = misc_q[4 +: SET_W];
  assign tim_o.act_m1   = tim_byte[REC_W +: ACT_W];
  assign tim_o.rec_m2   = tim_byte[REC_W-1:0];

  // R1
  set_a_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && idx_i == IDX_RD_TIM && !sel) |=> (rd_all[0] == $past(wdata_i)));
  // R1
  set_b_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel) |=> $stable(wr_all[1]) || $past(!rst_ni));
endmodule

// File: rtl/pio_cyc_seq.sv
module pio_cyc_seq
  import pio_cyc_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    req_i,
  input  logic    write_i,
  input  timing_t tim_i,
  output logic    busy_o,
  output logic    rd_strobe_o,
  output logic    wr_strobe_o,
  output logic    done_o
);
  phase_e ph_q;
  logic [CNT_W-1:0] cnt_q;
  timing_t tim_q;
  logic dir_q;
  logic last;

  assign last = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      tim_q <= '0;
      dir_q <= 1'b0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (req_i) begin
          ph_q  <= PH_SETUP;
          cnt_q <= CNT_W'(tim_i.setup_m1);
          tim_q <= tim_i;
          dir_q <= write_i;
        end
        PH_SETUP: if (last) begin
          ph_q  <= PH_ACTIVE;
          cnt_q <= CNT_W'(tim_q.act_m1);
        end else cnt_q <= cnt_q - 1'b1;
        PH_ACTIVE: if (last) begin
          ph_q  <= PH_RECOV;
          cnt_q <= CNT_W'(tim_q.rec_m2) + 1'b1;
        end else cnt_q <= cnt_q - 1'b1;
        PH_RECOV: if (last) ph_q <= PH_IDLE;
                  else cnt_q <= cnt_q - 1'b1;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign busy_o      = (ph_q != PH_IDLE);
  assign rd_strobe_o = (ph_q == PH_ACTIVE) && !dir_q;
  assign wr_strobe_o = (ph_q == PH_ACTIVE) && dir_q;
  assign done_o      = (ph_q == PH_RECOV) && last;

  // R9
  idle_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  // R8
  accept_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !req_i) |=> !busy_o);
  // R7
  strobe_after_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_strobe_o || wr_strobe_o) |-> $past(ph_q) == PH_SETUP);
  // R7
  no_strobe_on_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !(rd_strobe_o || wr_strobe_o));
  // R10
  snapshot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(tim_q) && $stable(dir_q)));
endmodule

// File: rtl/pio_cyc_gen.sv
module pio_cyc_gen
  import pio_cyc_pkg::*;
#(
  parameter bit STRAP_SLOW = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [IDX_W-1:0]  reg_idx_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              req_i,
  input  logic              req_drive_i,
  input  logic              req_write_i,
  output logic              busy_o,
  output logic              rd_strobe_o,
  output logic              wr_strobe_o,
  output logic              done_o
);
  timing_t tim;

  pio_cyc_regs #(.STRAP_SLOW(STRAP_SLOW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .idx_i   (reg_idx_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .drive_i (req_drive_i),
    .write_i (req_write_i),
    .tim_o   (tim)
  );

  pio_cyc_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .write_i     (req_write_i),
    .tim_i       (tim),
    .busy_o      (busy_o),
    .rd_strobe_o (rd_strobe_o),
    .wr_strobe_o (wr_strobe_o),
    .done_o      (done_o)
  );

  // R7
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({rd_strobe_o, wr_strobe_o}) <= 1);
endmodule

// File: tb/pio_cyc_gen_bench.sv
module pio_cyc_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0;
  logic [2:0] idx = '0;
  logic [7:0] wdata = '0, rdata;
  logic req = 1'b0, req_drive = 1'b0, req_write = 1'b0;
  logic busy, rd_stb, wr_stb, done;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pio_cyc_gen u_pio_cyc_gen (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_idx_i(idx),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .req_i(req),
    .req_drive_i(req_drive), .req_write_i(req_write), .busy_o(busy),
    .rd_strobe_o(rd_stb), .wr_strobe_o(wr_stb), .done_o(done)
  );

  typedef struct { int wr; int s; int a; int r; } exp_t;
  exp_t q[$];

  // register model
  logic [7:0] m_rd [2];
  logic [7:0] m_wr [2];
  logic [7:0] m_ctrl = '0, m_misc = '0;

  task automatic chk(string name, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", name, act, exp);
    end
  endtask

  task automatic wreg(logic [2:0] i, logic [7:0] d);
    @(negedge clk);
    we = 1'b1; idx = i; wdata = d;
    @(negedge clk);
    we = 1'b0;
    case (i)
      3'd0: m_rd[m_misc[0]] = d;
      3'd1: m_wr[m_misc[0]] = d;
      3'd3: m_ctrl = d;
      3'd6: m_misc = d;
      default: ;
    endcase
  endtask

  task automatic rchk(string name, logic [2:0] i, int exp);
    @(negedge clk);
    idx = i;
    #1;
    chk(name, int'(rdata), exp);
  endtask

  task automatic do_req(logic drv, logic wr);
    exp_t e;
    logic [7:0] b;
    int set;
    @(negedge clk);
    while (busy) @(negedge clk);
    set = (m_ctrl == 8'h85) ? int'(drv) : 0;
    b = wr ? m_wr[set] : m_rd[set];
    e.wr = int'(wr);
    e.s  = int'(m_misc[5:4]) + 1;
    e.a  = int'(b[7:4]) + 1;
    e.r  = int'(b[3:0]) + 2;
    q.push_back(e);
    req = 1'b1; req_drive = drv; req_write = wr;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_all;
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // monitor
  int m_s = 0, m_a = 0, m_r = 0, n_done = 0;
  bit m_sawrd = 0, m_sawwr = 0, prev_done = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done) chk("R9 idle after done", int'(busy), 0);
      prev_done = done;
      if (busy) begin
        if (rd_stb || wr_stb) begin
          m_a++; m_sawrd |= rd_stb; m_sawwr |= wr_stb;
        end else if (m_a == 0) m_s++;
        else m_r++;
        if (done) begin
          if (q.size() == 0) chk("R8 unexpected cycle", 1, 0);
          else begin
            exp_t e;
            e = q.pop_front();
            chk("R6 setup clocks", m_s, e.s);
            chk("R2 active clocks", m_a, e.a);
            chk("R2 recovery clocks", m_r, e.r);
            chk("R7 strobe kind", int'(m_sawwr), e.wr);
            chk("R7 single strobe", int'(m_sawwr && m_sawrd), 0);
          end
          n_done++;
          m_s = 0; m_a = 0; m_r = 0; m_sawrd = 0; m_sawwr = 0;
        end
      end else if (rd_stb || wr_stb || done) chk("R7 output while idle", 1, 0);
    end
  end

  initial begin
    m_rd[0] = '0; m_rd[1] = '0; m_wr[0] = '0; m_wr[1] = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 busy", int'(busy), 0);
    chk("R11 strobes", int'(rd_stb | wr_stb | done), 0);
    rst_n = 1'b1;
    rchk("R11 ctrl", 3'd3, 0);
    rchk("R11 misc", 3'd6, 0);
    rchk("R11 read timing", 3'd0, 0);
    rchk("R5 strap", 3'd5, 0);
    rchk("R1 unused index", 3'd4, 0);

    // R6 minimum lengths from reset values
    do_req(1'b0, 1'b0);
    do_req(1'b1, 1'b1);
    wait_all();

    // R1 R2 program both sets
    wreg(3'd6, 8'h00);
    wreg(3'd0, 8'h31);
    wreg(3'd1, 8'h52);
    wreg(3'd6, 8'h01);
    wreg(3'd0, 8'hF0);
    wreg(3'd1, 8'h0F);
    rchk("R1 set B read byte", 3'd0, 8'hF0);
    rchk("R1 set B write byte", 3'd1, 8'h0F);
    wreg(3'd3, 8'h85);
    wreg(3'd6, 8'h34);
    rchk("R3 misc readback", 3'd6, 8'h34);
    rchk("R1 set A read byte", 3'd0, 8'h31);
    rchk("R4 ctrl readback", 3'd3, 8'h85);

    // R4 split mapping, R3 shared setup of 4
    do_req(1'b0, 1'b0);
    do_req(1'b1, 1'b0);
    do_req(1'b0, 1'b1);
    do_req(1'b1, 1'b1);
    wait_all();

    // R4 non-split value: drive 1 uses set A
    wreg(3'd3, 8'h84);
    do_req(1'b1, 1'b0);
    do_req(1'b1, 1'b1);
    wait_all();

    // R3 setup of 1 and 3
    wreg(3'd6, 8'h20);
    do_req(1'b0, 1'b1);
    wait_all();

    // R10 write during a running cycle
    wreg(3'd3, 8'h85);
    wreg(3'd6, 8'h30);
    do_req(1'b0, 1'b0);
    wreg(3'd0, 8'h00);
    chk("R10 busy during write", int'(busy), 1);
    do_req(1'b0, 1'b0);
    wait_all();

    // R8 request while busy is dropped
    do_req(1'b1, 1'b0);
    @(negedge clk);
    req = 1'b1; req_drive = 1'b0; req_write = 1'b1;
    @(negedge clk);
    req = 1'b0;
    wait_all();
    repeat (5) @(negedge clk);
    chk("R8 no extra cycle", int'(busy), 0);
    chk("R8 queue drained", q.size(), 0);

    // R5 strap ignores writes
    wreg(3'd5, 8'hFF);
    rchk("R5 strap after write", 3'd5, 0);
    chk("R9 cycle count", n_done, 12);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule